// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the bit-level master of an I2C bus. It drives the clock and data lines as open-drain signals: each output is a "pull low" enable, and a released line is read high through an external pull-up resistor. Both lines are read back through two-flop synchronizers. A sequencer above the block issues one primitive at a time: start, write a byte, read a byte, or stop. The block performs the bus waveform for that primitive and then pulses `done`, together with a success flag, the slave's acknowledge (after a write) or the received byte (after a read). The sequencer chooses the acknowledge the master sends after each read byte.

All timing is counted in quarter-bit periods. A prescaler on the system clock produces one quarter tick every `qdiv+1` clocks, and the prescaler restarts whenever the state changes, so every phase lasts a whole number of quarters. Each time the engine releases SCL it waits one quarter and then polls SCL once per quarter. A slave that holds SCL low stretches the bit. If SCL is still low after `STRETCH_MAX` polls, the command ends with a failure and the engine returns to idle. A start is refused while another device holds SDA low. A stop is confirmed by reading SDA back high.

The controller is built on an enumerated state machine:

- **Start:** `S_ST_REL` (release SCL) → `S_ST_SDA` (release SDA, poll for a free bus) → `S_WAIT_HI` → `S_ST_LOW` (pull SDA low) → `S_ST_SCLL` (pull SCL low).
- **Write:** `S_WR_WAIT` → `S_WR_BIT` → `S_WAIT_HI`, repeated for each of the eight bits. The acknowledge bit then runs `S_WA_WAIT` → `S_WA_SDA` → `S_WAIT_HI` → `S_WA_HI` → `S_WA_LO`.
- **Read:** `S_WAIT_HI` → `S_RD_LO`, repeated for each bit. The master's acknowledge then runs `S_RA_WAIT` → `S_RA_BIT` → `S_WAIT_HI` → `S_RA_LO` → `S_RA_END`.
- **Stop:** `S_SP_SCL` → `S_SP_SDA` → `S_WAIT_HI` → `S_SP_REL`.
- **Shared wait:** `S_WAIT_HI` is the SCL-high wait used by every sequence. It returns to a stored state, or ends the command on timeout.

Every sequence ends in `S_IDLE`.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset both pull outputs are 0 (lines released), `ready` is 1 and `done` is 0.
- R2: A quarter lasts `qdiv+1` clocks. A start completes in 6 quarters with `ok`=1. It creates one SDA fall while SCL is high and leaves both lines low.
- R3: A write (`cmd_op`=2'd1) sends `cmd_wdata` MSB first. SDA changes only while SCL is low. A write with no stretching takes 40 quarters.
- R4: On the ninth clock of a write, `ack_rx` is 1 if SDA was low and 0 if it was high. `ok` equals `ack_rx`.
- R5: A read (`cmd_op`=2'd2) samples eight bits MSB first while SCL is high. `rdata` holds the byte at `done`. A read takes 38 quarters.
- R6: On the ninth clock of a read, the master pulls SDA low when `cmd_last`=0 (acknowledge) and leaves it released when `cmd_last`=1.
- R7: A stop (`cmd_op`=2'd3) takes 5 quarters. It creates an SDA rise while SCL is high, leaves both lines released, and reports `ok`=1.
- R8: If SDA still reads low on the third poll after the stop's final release, the stop reports `ok`=0 after 7 quarters.
- R9: A slave that holds SCL low for fewer than `STRETCH_MAX` polls delays the bit, and the command still completes correctly.
- R10: If SCL stays low for `STRETCH_MAX` polls, the command ends with `ok`=0 and the engine returns to idle. For a write this happens after `STRETCH_MAX+3` quarters.
- R11: A start (`cmd_op`=2'd0) on a bus whose SDA is held low fails after `1+START_TRIES` quarters with `ok`=0.
- R12: `done` is a single-cycle pulse. `ready` is 0 from acceptance until `done`, and a command is accepted only when `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qdiv | input | DIV_W | Quarter period in clocks, minus one (3 or more) |
| cmd_valid | input | 1 | Command request, taken when `ready` is 1 |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_wdata | input | 8 | Byte to write |
| cmd_last | input | 1 | Read: 1 sends NACK (last byte), 0 sends ACK |
| ready | output | 1 | Engine idle and able to take a command |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last command, valid from `done` |
| ack_rx | output | 1 | Slave acknowledge of the last write |
| rdata | output | 8 | Byte received by the last read |
| scl_in | input | 1 | SCL line as seen on the bus |
| sda_in | input | 1 | SDA line as seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the engine with `STRETCH_MAX`=6 and `START_TRIES`=3, which keeps the failure windows at 9, 4 and 7 quarters, short enough to reach within a brief run. It switches `qdiv` among values from 3 to 6 between commands, so every phase-length check is scaled by a quarter that varies. A bench slave on the open-drain lines returns random acknowledges and random read data. Directed cases hold SCL or SDA low to reach stretching, timeout, a busy start and a failed stop.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [4:0] {
        S_IDLE, S_ST_REL, S_ST_SDA, S_ST_LOW, S_ST_SCLL, S_WAIT_HI,
        S_WR_WAIT, S_WR_BIT, S_WA_WAIT, S_WA_SDA, S_WA_HI, S_WA_LO,
        S_RD_LO, S_RA_WAIT, S_RA_BIT, S_RA_LO, S_RA_END,
        S_SP_SCL, S_SP_SDA, S_SP_REL
    } st_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pc <= '0;
        else if (restart || pc == div) pc <= '0;
        else                          pc <= pc + DIV_W'(1);
    end

    assign tick = (pc == div);

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] ff [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ff[g] <= '1;
                else if (g == 0) ff[g] <= d;
                else             ff[g] <= ff[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int STRETCH_MAX = 8,
    parameter int START_TRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] qdiv,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_last,
    output logic             ready,
    output logic             done,
    output logic             ok,
    output logic             ack_rx,
    output logic [7:0]       rdata,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull
);
    localparam int CNT_MAX = (STRETCH_MAX > START_TRIES) ?
                             ((STRETCH_MAX > 2) ? STRETCH_MAX : 2) :
                             ((START_TRIES > 2) ? START_TRIES : 2);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] C_STR  = CNT_W'(STRETCH_MAX);
    localparam logic [CNT_W-1:0] C_TRY  = CNT_W'(START_TRIES - 1);
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_TWO  = CNT_W'(2);

    st_e              st, nxt, ret;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             last_q, scl_low, sda_low;
    logic             scl_s, sda_s, tick, fin, fin_ok;

    i2cm_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    i2cm_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(nxt != st), .div(qdiv), .tick(tick)
    );

    // next-state logic
    always_comb begin
        nxt    = st;
        fin    = 1'b0;
        fin_ok = 1'b0;
        unique case (st)
            S_IDLE: if (cmd_valid) begin
                case (cmd_op)
                    OP_START: nxt = S_ST_REL;
                    OP_WRITE: nxt = S_WR_WAIT;
                    OP_READ:  nxt = S_WAIT_HI;
                    default:  nxt = S_SP_SCL;
                endcase
            end
            S_ST_REL:  if (tick) nxt = S_ST_SDA;
            S_ST_SDA:  if (tick) begin
                if (sda_s)             nxt = S_WAIT_HI;
                else if (cnt == C_TRY) fin = 1'b1;
            end
            S_ST_LOW:  if (tick) nxt = S_ST_SCLL;
            S_ST_SCLL: if (tick) begin fin = 1'b1; fin_ok = 1'b1; end
            S_WAIT_HI: if (tick) begin
                if (cnt != '0 && scl_s) nxt = ret;
                else if (cnt == C_STR)  fin = 1'b1;
            end
            S_WR_WAIT: if (tick) nxt = S_WR_BIT;
            S_WR_BIT:  if (tick) nxt = S_WAIT_HI;
            S_WA_WAIT: if (tick) nxt = S_WA_SDA;
            S_WA_SDA:  if (tick) nxt = S_WAIT_HI;
            S_WA_HI:   if (tick && cnt == C_ONE) nxt = S_WA_LO;
            S_WA_LO:   if (tick && cnt == C_ONE) begin fin = 1'b1; fin_ok = ack_rx; end
            S_RD_LO:   if (tick && cnt == C_ONE) nxt = (bitn == 3'd0) ? S_RA_WAIT : S_WAIT_HI;
            S_RA_WAIT: if (tick) nxt = S_RA_BIT;
            S_RA_BIT:  if (tick) nxt = S_WAIT_HI;
            S_RA_LO:   if (tick) nxt = S_RA_END;
            S_RA_END:  if (tick) begin fin = 1'b1; fin_ok = 1'b1; end
            S_SP_SCL:  if (tick) nxt = S_SP_SDA;
            S_SP_SDA:  if (tick) nxt = S_WAIT_HI;
            S_SP_REL:  if (tick) begin
                if (sda_s)             begin fin = 1'b1; fin_ok = 1'b1; end
                else if (cnt == C_TWO) fin = 1'b1;
            end
            default:   nxt = S_IDLE;
        endcase
        if (fin) nxt = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // outputs and datapath, driven on entry to the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_low <= 1'b0; sda_low <= 1'b0; done <= 1'b0; ok <= 1'b0;
            ack_rx  <= 1'b0; rdata <= '0; shreg <= '0; bitn <= '0;
            ret     <= S_IDLE; cnt <= '0; last_q <= 1'b0;
        end else begin
            done <= fin;
            if (fin) ok <= fin_ok;
            if (nxt != st)                   cnt <= '0;
            else if (tick && st != S_IDLE)   cnt <= cnt + C_ONE;

            if (st == S_IDLE && cmd_valid) begin
                shreg  <= cmd_wdata;
                bitn   <= 3'd7;
                last_q <= cmd_last;
                if (cmd_op == OP_READ) begin
                    ret     <= S_RD_LO;
                    sda_low <= 1'b0;
                end
            end

            if (nxt != st) begin
                case (nxt)
                    S_ST_REL, S_WAIT_HI:                 scl_low <= 1'b0;
                    S_ST_SDA, S_WA_SDA, S_RA_END, S_SP_REL: sda_low <= 1'b0;
                    S_ST_LOW, S_SP_SDA:                  sda_low <= 1'b1;
                    S_ST_SCLL, S_WR_WAIT, S_WA_WAIT, S_WA_LO,
                    S_RD_LO, S_RA_LO, S_SP_SCL:          scl_low <= 1'b1;
                    S_WR_BIT:                            sda_low <= ~shreg[bitn];
                    S_RA_BIT:                            sda_low <= ~last_q;
                    default: ;
                endcase
            end

            if (nxt == S_WAIT_HI && st != S_WAIT_HI) begin
                case (st)
                    S_ST_SDA: ret <= S_ST_LOW;
                    S_WR_BIT: begin
                        ret  <= (bitn == 3'd0) ? S_WA_WAIT : S_WR_WAIT;
                        bitn <= bitn - 3'd1;
                    end
                    S_WA_SDA: ret <= S_WA_HI;
                    S_RD_LO:  begin ret <= S_RD_LO; bitn <= bitn - 3'd1; end
                    S_RA_BIT: ret <= S_RA_LO;
                    S_SP_SDA: ret <= S_SP_REL;
                    default: ;
                endcase
            end
            if (st == S_WAIT_HI && nxt == S_RD_LO) shreg  <= {shreg[6:0], sda_s};
            if (st == S_WAIT_HI && nxt == S_WA_HI) ack_rx <= ~sda_s;
            if (st == S_RD_LO && nxt == S_RA_WAIT) rdata  <= shreg;
        end
    end

    assign ready    = (st == S_IDLE);
    assign scl_pull = scl_low;
    assign sda_pull = sda_low;

    // R3
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT_HI && $past(st) == S_WAIT_HI) |-> $stable(sda_pull));
    // R10
    stretch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT_HI) |-> (cnt <= C_STR));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);
    // R1
    reset_rel_chk: assert property (@(posedge clk)
        !rst_n |=> (!scl_pull && !sda_pull));
endmodule

// File: tb/sim_i2c_bit_master.sv
module sim_i2c_bit_master;
    localparam int CLK_PERIOD = 10;
    localparam int SM = 6;
    localparam int ST = 3;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [7:0] qdiv = 8'd3;
    logic       cmd_valid = 1'b0, cmd_last = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_wdata = '0;
    logic       ready, done, ok, ack_rx, scl_pull, sda_pull;
    logic [7:0] rdata;
    logic       slv_scl = 1'b0, slv_sda = 1'b0;
    logic       scl_line, sda_line;
    int         checks = 0, errors = 0, n_start = 0, n_stop = 0;
    bit         ended = 1'b0;

    assign scl_line = !(scl_pull || slv_scl);
    assign sda_line = !(sda_pull || slv_sda);

    i2c_bit_master #(.DIV_W(8), .STRETCH_MAX(SM), .START_TRIES(ST)) u0 (
        .clk(clk), .rst_n(rst_n), .qdiv(qdiv), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
        .ready(ready), .done(done), .ok(ok), .ack_rx(ack_rx), .rdata(rdata),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge sda_line) if (scl_line) n_start++;
    always @(posedge sda_line) if (scl_line) n_stop++;

    function automatic int exp_quarters(input logic [1:0] op);
        case (op)
            2'd0: return 6;
            2'd1: return 40;
            2'd2: return 38;
            default: return 5;
        endcase
    endfunction

    function automatic int qlen();
        return int'(qdiv) + 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] wd, input logic lst,
                         output int cyc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_last = lst;
        @(posedge clk);
        cyc = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input logic ack, input int stretch,
                            input string tag);
        int cyc; logic [7:0] got;
        if (stretch > 0) slv_scl = 1'b1;
        fork
            issue(2'd1, d, 1'b0, cyc);
            begin
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl_line); got[7-i] = sda_line;
                    @(negedge scl_line);
                end
                slv_sda = ack;
                @(posedge scl_line); @(negedge scl_line);
                slv_sda = 1'b0;
            end
            begin
                if (stretch > 0) begin
                    repeat (stretch) @(posedge clk);
                    #1 slv_scl = 1'b0;
                end
            end
        join
        check({tag, " R3 byte"}, {24'd0, got}, {24'd0, d});
        check({tag, " R4 ack_rx"}, {31'd0, ack_rx}, {31'd0, ack});
        check({tag, " R4 ok"}, {31'd0, ok}, {31'd0, ack});
        if (stretch == 0)
            check({tag, " R3 cycles"}, cyc, exp_quarters(2'd1) * qlen());
    endtask

    task automatic do_read(input logic [7:0] d, input logic lst);
        int cyc; logic mack;
        fork
            issue(2'd2, 8'h00, lst, cyc);
            begin
                slv_sda = !d[7];
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl_line); @(negedge scl_line);
                    slv_sda = (i < 7) ? !d[6-i] : 1'b0;
                end
                @(posedge scl_line); mack = sda_line;
            end
        join
        check("R5 rdata", {24'd0, rdata}, {24'd0, d});
        check("R5 cycles", cyc, exp_quarters(2'd2) * qlen());
        check("R6 master ack level", {31'd0, mack}, {31'd0, lst});
        check("R5 ok", {31'd0, ok}, 32'd1);
    endtask

    task automatic do_start();
        int cyc, s0;
        s0 = n_start;
        issue(2'd0, 8'h00, 1'b0, cyc);
        check("R2 start cycles", cyc, exp_quarters(2'd0) * qlen());
        check("R2 start ok", {31'd0, ok}, 32'd1);
        check("R2 start event", n_start - s0, 32'd1);
        check("R2 lines low", {30'd0, scl_line, sda_line}, 32'd0);
    endtask

    task automatic do_stop();
        int cyc, p0;
        p0 = n_stop;
        issue(2'd3, 8'h00, 1'b0, cyc);
        check("R7 stop cycles", cyc, exp_quarters(2'd3) * qlen());
        check("R7 stop ok", {31'd0, ok}, 32'd1);
        check("R7 stop event", n_stop - p0, 32'd1);
        check("R7 lines high", {30'd0, scl_line, sda_line}, 32'd3);
    endtask

    initial begin
        int cyc, nb;
        logic [7:0] rb;
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 scl_pull", {31'd0, scl_pull}, 32'd0);
        check("R1 sda_pull", {31'd0, sda_pull}, 32'd0);
        check("R1 ready", {31'd0, ready}, 32'd1);
        check("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed first round with busy/pulse checks
        do_start();
        @(negedge clk);
        check("R12 done single cycle", {31'd0, done}, 32'd0);
        fork
            do_write(8'hA5, 1'b0, 0, "w0");
            begin
                repeat (3) @(negedge clk);
                check("R12 ready low while busy", {31'd0, ready}, 32'd0);
            end
        join
        do_write(8'h3C, 1'b1, 0, "w1 nack");
        do_stop();

        // random rounds
        for (int r = 0; r < 6; r++) begin
            qdiv = 8'(3 + ($urandom % 4));
            do_start();
            do_write(8'($urandom), 1'($urandom), 0, "wr");
            nb = 1 + int'($urandom % 3);
            for (int b = 0; b < nb; b++) begin
                rb = 8'($urandom);
                do_read(rb, (b == nb - 1));
            end
            do_stop();
        end

        // R9 stretch within limit
        qdiv = 8'd3;
        do_start();
        do_write(8'h96, 1'b0, 20, "R9 stretch");
        do_stop();

        // R10 stretch timeout
        do_start();
        slv_scl = 1'b1;
        issue(2'd1, 8'h5A, 1'b0, cyc);
        check("R10 timeout cycles", cyc, (SM + 3) * qlen());
        check("R10 timeout ok", {31'd0, ok}, 32'd0);
        check("R10 idle after timeout", {31'd0, ready}, 32'd1);
        slv_scl = 1'b0;
        repeat (4) @(negedge clk);
        do_stop();

        // R8 failed stop
        slv_sda = 1'b1;
        issue(2'd3, 8'h00, 1'b0, cyc);
        check("R8 stop fail cycles", cyc, 7 * qlen());
        check("R8 stop fail ok", {31'd0, ok}, 32'd0);

        // R11 busy bus at start
        issue(2'd0, 8'h00, 1'b0, cyc);
        check("R11 start fail cycles", cyc, (1 + ST) * qlen());
        check("R11 start fail ok", {31'd0, ok}, 32'd0);
        slv_sda = 1'b0;
        repeat (4) @(negedge clk);
        do_start();
        do_stop();

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            checks++; errors++;
            $display("FAIL R12 watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule